// File: doc/BRIEF.md
# Hiccup Overload Protection Sequencer

This block decides whether the output power stage may supply current. It watches an overload-detect input and a slow timing tick, usually one pulse per millisecond, and drives a stage-enable signal and an overload flag that software can read back. A mode input selects one of two protection policies, and the mode can be changed while the block runs.

In the pulsed policy the block runs a hiccup cycle. When an overload first appears, the stage stays on for a short on window. The block then shuts the stage off for a period ten times as long and turns it back on for a retry window. The flag rises at the moment of shutdown. It stays high through every off period and retry window, and it clears only after a retry window in which no overload was seen. In the clamp policy the stage is never switched off, and the flag simply mirrors the overload input.

Top module: `hiccup_guard`

## Requirements
- R1: After reset, `stageEnable` is 1 and `overloadFlag` is 0.
- R2: With `staticMode`=0 (pulsed policy) in the idle state, an overload starts an on window of ON_TICKS tick pulses, counted from the next clock edge. During this window `stageEnable` stays 1 and `overloadFlag` stays 0.
- R3: On the clock edge that takes the last tick of the first on window, `stageEnable` falls to 0 and `overloadFlag` rises to 1 together.
- R4: The off phase lasts OFF_RATIO*ON_TICKS tick pulses. On the edge that takes its last tick, `stageEnable` returns to 1 for a retry window of ON_TICKS ticks, and `overloadFlag` stays 1.
- R5: If overload is high in any cycle of a retry window, even for a single cycle, the stage turns off again at the end of that window and `overloadFlag` stays 1.
- R6: If a retry window passes with no overload, the block returns to the idle state at the end of that window, and `overloadFlag` clears to 0 on the same edge.
- R7: With `staticMode`=1 (clamp policy), `stageEnable` is always 1, and `overloadFlag` takes the value that `overload` had at the previous clock edge.
- R8: Raising `staticMode` during an off phase sets `stageEnable` to 1 in the same cycle, before the next clock edge.
- R9: After `staticMode` returns to 0, an overload starts the pulsed sequence of R2 and R3.
- R10: In the pulsed idle state with no overload, tick pulses have no effect: `stageEnable` stays 1 and `overloadFlag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle timing pulse (one per millisecond in use) |
| overload | input | 1 | Overload detected by the current sensing |
| staticMode | input | 1 | 1 = clamp policy, 0 = pulsed hiccup policy |
| stageEnable | output | 1 | 1 allows the power stage to supply current |
| overloadFlag | output | 1 | Overload status bit for read-back |

## Verification
The bench builds the block with ON_TICKS=3 and the default OFF_RATIO of 10, so an off phase is 30 tick pulses. The bench drives each tick pulse itself. With such short windows, the bench can place a probe on the cycle just before and just after every window boundary. Several complete hiccup cycles, a one-cycle overload inside a retry window and mode changes in the middle of an off phase all fit in a few hundred clock cycles.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FIRST_ON = 2'd1,
    ST_OFF      = 2'd2,
    ST_RETRY_ON = 2'd3
  } guard_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClear;
    logic dirtyClear;
    logic flagSet;
    logic flagClear;
    logic flagFollow;
  } guard_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic onDone;
    logic offDone;
    logic sawOverload;
  } guard_status_t;

endpackage

// File: rtl/hiccup_dp.sv
module hiccup_dp
  import hiccup_pkg::*;
#(
  parameter int ON_TICKS  = 90,
  parameter int OFF_RATIO = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          overload,
  input  guard_strobe_t strobe,
  output guard_status_t status,
  output logic          overloadFlag
);

  localparam int OFF_TICKS = ON_TICKS * OFF_RATIO;
  localparam int CNT_W     = $clog2(OFF_TICKS + 1);
  localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_TICKS - 1);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic             dirtyQ;
  logic             flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.cntClear) begin
      tickCnt <= '0;
    end else if (tick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirtyQ <= 1'b0;
    end else if (strobe.dirtyClear) begin
      dirtyQ <= 1'b0;
    end else if (overload) begin
      dirtyQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strobe.flagFollow) begin
      flagQ <= overload;
    end else if (strobe.flagSet) begin
      flagQ <= 1'b1;
    end else if (strobe.flagClear) begin
      flagQ <= 1'b0;
    end
  end

  always_comb begin
    status.onDone      = tick && (tickCnt == ON_LAST);
    status.offDone     = tick && (tickCnt == OFF_LAST);
    status.sawOverload = dirtyQ || overload;
  end

  assign overloadFlag = flagQ;

endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl
  import hiccup_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          overload,
  input  logic          staticMode,
  input  guard_status_t status,
  output guard_strobe_t strobe,
  output logic          stageEnable
);

  guard_state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (staticMode) begin
      nextState         = ST_IDLE;
      strobe.cntClear   = 1'b1;
      strobe.dirtyClear = 1'b1;
      strobe.flagFollow = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          strobe.cntClear   = 1'b1;
          strobe.dirtyClear = 1'b1;
          strobe.flagClear  = 1'b1;
          if (overload) nextState = ST_FIRST_ON;
        end
        ST_FIRST_ON: begin
          if (status.onDone) begin
            nextState       = ST_OFF;
            strobe.cntClear = 1'b1;
            strobe.flagSet  = 1'b1;
          end
        end
        ST_OFF: begin
          if (status.offDone) begin
            nextState         = ST_RETRY_ON;
            strobe.cntClear   = 1'b1;
            strobe.dirtyClear = 1'b1;
          end
        end
        ST_RETRY_ON: begin
          if (status.onDone) begin
            strobe.cntClear = 1'b1;
            if (status.sawOverload) begin
              nextState      = ST_OFF;
              strobe.flagSet = 1'b1;
            end else begin
              nextState        = ST_IDLE;
              strobe.flagClear = 1'b1;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign stageEnable = staticMode || (state != ST_OFF);

endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
  import hiccup_pkg::*;
#(
  parameter int ON_TICKS  = 90,
  parameter int OFF_RATIO = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic overload,
  input  logic staticMode,
  output logic stageEnable,
  output logic overloadFlag
);

  guard_strobe_t strobe;
  guard_status_t status;

  hiccup_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .overload   (overload),
    .staticMode (staticMode),
    .status     (status),
    .strobe     (strobe),
    .stageEnable(stageEnable)
  );

  hiccup_dp #(
    .ON_TICKS (ON_TICKS),
    .OFF_RATIO(OFF_RATIO)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .overload    (overload),
    .strobe      (strobe),
    .status      (status),
    .overloadFlag(overloadFlag)
  );

endmodule

// File: rtl/hiccup_guard_chk.sv
module hiccup_guard_chk (
  input logic clk,
  input logic rstN,
  input logic overload,
  input logic staticMode,
  input logic stageEnable,
  input logic overloadFlag
);

  // R7
  clamp_keeps_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    staticMode |-> stageEnable);

  // R7
  clamp_flag_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (staticMode && $past(staticMode) && $past(rstN)) |-> (overloadFlag == $past(overload)));

  // R3
  shutdown_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stageEnable) && !staticMode) |-> overloadFlag);

  // R4
  off_implies_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stageEnable |-> overloadFlag);

  // R4
  retry_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(stageEnable) && !staticMode) |-> overloadFlag);

  // R6
  clear_only_when_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(overloadFlag) && !staticMode && !$past(staticMode)) |-> stageEnable);

endmodule

bind hiccup_guard hiccup_guard_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .overload    (overload),
  .staticMode  (staticMode),
  .stageEnable (stageEnable),
  .overloadFlag(overloadFlag)
);

// File: tb/hiccup_guard_test.sv
module hiccup_guard_test;

  localparam int CLK_PERIOD = 10;
  localparam int ON_T       = 3;
  localparam int RATIO      = 10;
  localparam int OFF_T      = ON_T * RATIO;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic overload = 1'b0;
  logic staticMode = 1'b0;
  logic stageEnable;
  logic overloadFlag;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiccup_guard #(.ON_TICKS(ON_T), .OFF_RATIO(RATIO)) uut (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .overload    (overload),
    .staticMode  (staticMode),
    .stageEnable (stageEnable),
    .overloadFlag(overloadFlag)
  );

  task automatic check(input string req, input string what,
                       input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, actual, expected);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  // enter the off phase from the pulsed idle state with overload held high
  task automatic enterOff();
    overload = 1'b1;
    cycles(1);
    ticks(ON_T);
  endtask

  task automatic testReset();
    check("R1", "enable after reset", stageEnable, 1'b1);
    check("R1", "flag after reset", overloadFlag, 1'b0);
  endtask

  task automatic testIdleTicks();
    ticks(OFF_T + 5);
    check("R10", "enable idle ticks", stageEnable, 1'b1);
    check("R10", "flag idle ticks", overloadFlag, 1'b0);
  endtask

  task automatic testHiccup();
    overload = 1'b1;
    cycles(1);
    ticks(ON_T - 1);
    check("R2", "enable before first window end", stageEnable, 1'b1);
    check("R2", "flag before first window end", overloadFlag, 1'b0);
    ticks(1);
    check("R3", "enable at shutdown", stageEnable, 1'b0);
    check("R3", "flag at shutdown", overloadFlag, 1'b1);
    ticks(OFF_T - 1);
    check("R4", "enable before off end", stageEnable, 1'b0);
    ticks(1);
    check("R4", "enable in retry", stageEnable, 1'b1);
    check("R4", "flag in retry", overloadFlag, 1'b1);
    ticks(ON_T);
    check("R5", "enable after dirty retry", stageEnable, 1'b0);
    check("R5", "flag after dirty retry", overloadFlag, 1'b1);
    overload = 1'b0;
    ticks(OFF_T);
    check("R4", "second retry enable", stageEnable, 1'b1);
    ticks(ON_T - 1);
    check("R6", "flag held inside clean retry", overloadFlag, 1'b1);
    ticks(1);
    check("R6", "enable after clean retry", stageEnable, 1'b1);
    check("R6", "flag after clean retry", overloadFlag, 1'b0);
    ticks(ON_T + 2);
    check("R6", "back to idle stays on", stageEnable, 1'b1);
  endtask

  task automatic testBriefGlitch();
    enterOff();
    overload = 1'b0;
    ticks(OFF_T);
    overload = 1'b1;
    cycles(1);
    overload = 1'b0;
    ticks(ON_T);
    check("R5", "one-cycle overload forces off", stageEnable, 1'b0);
    check("R5", "flag held after glitch", overloadFlag, 1'b1);
    ticks(OFF_T + ON_T);
    check("R6", "recovered after glitch", overloadFlag, 1'b0);
  endtask

  task automatic testStatic();
    staticMode = 1'b1;
    overload = 1'b1;
    cycles(1);
    check("R7", "flag follows overload high", overloadFlag, 1'b1);
    ticks(OFF_T + ON_T + 4);
    check("R7", "clamp never shuts down", stageEnable, 1'b1);
    overload = 1'b0;
    check("R7", "flag not yet updated", overloadFlag, 1'b1);
    cycles(1);
    check("R7", "flag follows overload low", overloadFlag, 1'b0);
    staticMode = 1'b0;
    cycles(1);
  endtask

  task automatic testSwitchInOff();
    enterOff();
    ticks(4);
    check("R8", "off before switch", stageEnable, 1'b0);
    staticMode = 1'b1;
    #1;
    check("R8", "enable at once after switch", stageEnable, 1'b1);
    cycles(1);
    check("R8", "flag follows static rule", overloadFlag, 1'b1);
    overload = 1'b0;
    cycles(1);
    check("R8", "flag clears with overload", overloadFlag, 1'b0);
  endtask

  task automatic testBackToDynamic();
    staticMode = 1'b0;
    cycles(2);
    check("R9", "idle after return", overloadFlag, 1'b0);
    overload = 1'b1;
    cycles(1);
    ticks(ON_T - 1);
    check("R9", "window running", stageEnable, 1'b1);
    ticks(1);
    check("R9", "pulsed shutdown", stageEnable, 1'b0);
    check("R9", "pulsed flag", overloadFlag, 1'b1);
    overload = 1'b0;
    ticks(OFF_T + ON_T);
    check("R9", "pulsed recovery", overloadFlag, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cycles(3);
    rstN = 1'b1;
    cycles(1);
    testReset();
    testIdleTicks();
    testHiccup();
    testBriefGlitch();
    testStatic();
    testSwitchInOff();
    testBackToDynamic();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule